// File: doc/BRIEF.md
# Multiplexed Five-Segment Capacity Bar Driver

This block turns a remaining-charge count and a learned full-capacity count into a five-segment bar graph. Each segment stands for one fifth of the learned capacity. The segments are split into two banks that take turns on a shared LED common line. The odd-numbered segments (1, 3, 5) form bank A and the even-numbered segments (2, 4) form bank B. Each bank is lit for 30% of a multiplex frame. At the default prescaler rate of 1 kHz, a frame repeats at 100 Hz.

A three-state display control selects how the bar is turned on. High (or the unused code) forces the bar dark. Floating shows the bar whenever a charge is in progress. Pulling the input low acts as a push-button: it opens a timed viewing window of about 4 s, and a fresh press during that window starts the window again. Two battery flags are laid over the picture. The early-empty flag makes segment 1 blink at 4 Hz. The final-empty flag blanks every segment.

All timing comes from a single-cycle `tick` strobe supplied by a prescaler outside the block. The display controller is a three-state machine:
- `ST_IDLE` is the dark state.
- `ST_WINDOW` is the timed push-button view.
- `ST_CHARGE` shows the bar while charging.

The controller has the following transitions:
- `force_off`: from any state to `ST_IDLE` when the control is high.
- `press`: from any state to `ST_WINDOW` on entry into low.
- `show_chg`: from `ST_IDLE` to `ST_CHARGE` when the control is floating and charging is active.
- `chg_end`: from `ST_CHARGE` to `ST_IDLE` when that condition drops.
- `expire`: from `ST_WINDOW` to `ST_IDLE`, or to `ST_CHARGE` if the charge condition holds, when the window timer runs out.

Top module: `ledbar_drv`

## Requirements
- R1: Segment k (k = 1..5, driven on `seg_out[k-1]`) qualifies to light when 5·`avail` > (k−1)·`learned`. Segment 1 therefore qualifies exactly when `avail` > 0, and every segment qualifies once `avail` exceeds `learned`.
- R2: Bank timing:
  - The multiplex phase runs from 0 to FRAME_TICKS−1 and advances once per `tick`.
  - Bank A (`seg_out` bits 0, 2, 4) may light during phases 0..ON_TICKS−1.
  - Bank B (bits 1, 3) may light during phases FRAME_TICKS/2 .. FRAME_TICKS/2+ON_TICKS−1.
  - `com_out` is high during both of these intervals while the display is enabled. With the defaults (10, 3), this gives 30% per bank.
- R3: `disp_mode` = 2'b10 (high) or 2'b11 forces the display off. Every segment and `com_out` stay low.
- R4: `disp_mode` = 2'b01 (floating) enables the display exactly while `charging` is high.
- R5: Entry into `disp_mode` = 2'b00 (low) from any other code opens a window of WINDOW_TICKS ticks (4000 by default, which is 4 s at 1 kHz). The display is on during the window and off after it, even if the input is held low. A low level present when reset is released counts as an entry.
- R6: A new entry into low during an open window restarts the window count from zero.
- R7: While `early_empty` is high, segment 1 is additionally gated by a blink phase. The blink phase toggles every BLINK_HALF_TICKS ticks (125 by default, which is 4 Hz at 1 kHz) and starts in its visible half after reset. No other segment is affected.
- R8: `final_empty` high turns every segment output off on the next cycle. `com_out` is unaffected.
- R9: `com_out` is low whenever the display is not enabled.
- R10: Timing and reset:
  - Outputs are registered: a change on `avail`, `learned`, `early_empty` or `final_empty` appears after one clock edge.
  - A change on `disp_mode` or `charging` appears after two clock edges.
  - Reset drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler strobe, one cycle wide |
| avail | input | W | Compensated available count |
| learned | input | W | Learned full capacity count |
| disp_mode | input | 2 | Display control: 00 low, 01 floating, 10/11 high |
| charging | input | 1 | Charge in progress |
| early_empty | input | 1 | Early-empty warning flag |
| final_empty | input | 1 | Final-empty flag |
| seg_out | output | NSEG | Segment enables, bit 0 = segment 1 |
| com_out | output | 1 | LED common enable |

## Verification
Segment levels and the two empty flags reach the ports one edge after they change. Display-control and charge changes need two edges, because they first move the state machine and then pass through the output register. Window expiry and blink toggles land exactly on the tick count given in R5 and R7. The bench holds a behavioural model that advances at each rising edge from the same stimulus, and it compares both outputs at every falling edge. Directed counts of lit cycles are taken only after waiting at least three cycles past any stimulus, so the two-edge latency has settled before counting starts.

// File: rtl/ledbar_pkg.sv
package ledbar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_CHARGE = 2'd2
    } disp_state_t;

    localparam logic [1:0] MODE_PRESS = 2'b00;
    localparam logic [1:0] MODE_FLOAT = 2'b01;

endpackage

// File: rtl/ledbar_level.sv
module ledbar_level #(
    parameter int W    = 16,
    parameter int NSEG = 5
) (
    input  logic [W-1:0]    avail,
    input  logic [W-1:0]    learned,
    output logic [NSEG-1:0] lit
);
    localparam int EW = W + $clog2(NSEG + 1) + 1;

    logic [EW-1:0] avail_scaled;

    assign avail_scaled = EW'(avail) * EW'(NSEG);

    // segment k qualifies when avail exceeds k fifths of learned
    generate
        for (genvar k = 0; k < NSEG; k++) begin : g_thr
            logic [EW-1:0] thr;
            assign thr    = EW'(learned) * EW'(k);
            assign lit[k] = avail_scaled > thr;
        end
    endgenerate

endmodule

// File: rtl/ledbar_mux.sv
module ledbar_mux #(
    parameter int FRAME_TICKS      = 10,
    parameter int ON_TICKS         = 3,
    parameter int BLINK_HALF_TICKS = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic bank_a,
    output logic bank_b,
    output logic blink_vis
);
    localparam int PW   = (FRAME_TICKS > 2) ? $clog2(FRAME_TICKS) : 1;
    localparam int BW   = (BLINK_HALF_TICKS > 2) ? $clog2(BLINK_HALF_TICKS) : 1;
    localparam int HALF = FRAME_TICKS / 2;
    localparam logic [PW-1:0] PH_LAST = PW'(FRAME_TICKS - 1);
    localparam logic [BW-1:0] BL_LAST = BW'(BLINK_HALF_TICKS - 1);

    logic [PW-1:0] phase_q;
    logic [BW-1:0] blink_cnt_q;
    logic          vis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blink_cnt_q <= '0;
            vis_q       <= 1'b1;
        end else if (tick) begin
            if (blink_cnt_q == BL_LAST) begin
                blink_cnt_q <= '0;
                vis_q       <= ~vis_q;
            end else begin
                blink_cnt_q <= blink_cnt_q + 1'b1;
            end
        end
    end

    assign bank_a    = phase_q < PW'(ON_TICKS);
    assign bank_b    = (phase_q >= PW'(HALF)) && (phase_q < PW'(HALF + ON_TICKS));
    assign blink_vis = vis_q;

endmodule

// File: rtl/ledbar_ctrl.sv
module ledbar_ctrl
    import ledbar_pkg::*;
#(
    parameter int WINDOW_TICKS = 4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [1:0]  mode,
    input  logic        charging,
    output disp_state_t state,
    output logic        disp_en
);
    localparam int TW = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
    localparam logic [TW-1:0] TMR_LAST = TW'(WINDOW_TICKS - 1);

    disp_state_t   state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          low_seen_q;
    logic          force_off, press, show_chg;

    assign force_off = mode[1];
    assign press     = (mode == MODE_PRESS) && !low_seen_q;
    assign show_chg  = (mode == MODE_FLOAT) && charging;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (force_off) begin
            state_d = ST_IDLE;
            tmr_d   = '0;
        end else if (press) begin
            state_d = ST_WINDOW;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (show_chg) state_d = ST_CHARGE;
                end
                ST_WINDOW: begin
                    if (tick) begin
                        if (tmr_q == TMR_LAST) begin
                            tmr_d   = '0;
                            state_d = show_chg ? ST_CHARGE : ST_IDLE;
                        end else begin
                            tmr_d = tmr_q + 1'b1;
                        end
                    end
                end
                ST_CHARGE: begin
                    if (!show_chg) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tmr_q      <= '0;
            low_seen_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            tmr_q      <= tmr_d;
            low_seen_q <= (mode == MODE_PRESS);
        end
    end

    always_comb begin
        state   = state_q;
        disp_en = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/ledbar_drv.sv
module ledbar_drv
    import ledbar_pkg::*;
#(
    parameter int W                = 16,
    parameter int NSEG             = 5,
    parameter int FRAME_TICKS      = 10,
    parameter int ON_TICKS         = 3,
    parameter int BLINK_HALF_TICKS = 125,
    parameter int WINDOW_TICKS     = 4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [W-1:0]    avail,
    input  logic [W-1:0]    learned,
    input  logic [1:0]      disp_mode,
    input  logic            charging,
    input  logic            early_empty,
    input  logic            final_empty,
    output logic [NSEG-1:0] seg_out,
    output logic            com_out
);
    logic [NSEG-1:0] lit;
    logic [NSEG-1:0] seg_d;
    logic            bank_a, bank_b, blink_vis;
    logic            disp_en;
    logic            com_d;
    disp_state_t     disp_state;

    ledbar_level #(.W(W), .NSEG(NSEG)) u_level (
        .avail   (avail),
        .learned (learned),
        .lit     (lit)
    );

    ledbar_mux #(
        .FRAME_TICKS      (FRAME_TICKS),
        .ON_TICKS         (ON_TICKS),
        .BLINK_HALF_TICKS (BLINK_HALF_TICKS)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bank_a    (bank_a),
        .bank_b    (bank_b),
        .blink_vis (blink_vis)
    );

    ledbar_ctrl #(.WINDOW_TICKS(WINDOW_TICKS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (disp_mode),
        .charging (charging),
        .state    (disp_state),
        .disp_en  (disp_en)
    );

    // per-segment gating: bank by segment parity, blink only on segment 1
    generate
        for (genvar k = 0; k < NSEG; k++) begin : g_seg
            logic in_bank, blink_ok;
            if (k % 2 == 0) begin : g_a
                assign in_bank = bank_a;
            end else begin : g_b
                assign in_bank = bank_b;
            end
            if (k == 0) begin : g_blink
                assign blink_ok = !early_empty || blink_vis;
            end else begin : g_steady
                assign blink_ok = 1'b1;
            end
            assign seg_d[k] = disp_en && !final_empty && lit[k] && in_bank && blink_ok;
        end
    endgenerate

    assign com_d = disp_en && (bank_a || bank_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_out <= '0;
            com_out <= 1'b0;
        end else begin
            seg_out <= seg_d;
            com_out <= com_d;
        end
    end

endmodule

// File: rtl/ledbar_drv_chk.sv
module ledbar_drv_chk #(
    parameter int NSEG = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      disp_mode,
    input logic            final_empty,
    input logic            disp_en,
    input logic [NSEG-1:0] seg_out,
    input logic            com_out
);
    function automatic logic [NSEG-1:0] bank_a_mask();
        logic [NSEG-1:0] m;
        for (int i = 0; i < NSEG; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction

    localparam logic [NSEG-1:0] MASK_A = bank_a_mask();
    localparam logic [NSEG-1:0] MASK_B = ~MASK_A;

    // R8: final-empty blanks every segment on the following cycle
    p_dark_on_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        final_empty |=> (seg_out == '0));

    // R2: the two banks never light together
    p_banks_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(((seg_out & MASK_A) != '0) && ((seg_out & MASK_B) != '0)));

    // R2: a lit segment always has its common enabled
    p_seg_needs_com_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_out != '0) |-> com_out);

    // R3: a high control held for two cycles leaves the common dark
    p_off_when_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode[1] && $past(disp_mode[1])) |=> !com_out);

    // R9: common only follows an enabled display
    p_com_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        com_out |-> $past(disp_en));

endmodule

bind ledbar_drv ledbar_drv_chk #(.NSEG(NSEG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_mode   (disp_mode),
    .final_empty (final_empty),
    .disp_en     (disp_en),
    .seg_out     (seg_out),
    .com_out     (com_out)
);

// File: tb/ledbar_drv_test.sv
`timescale 1ns/1ps
module ledbar_drv_test;
    localparam int W   = 16;
    localparam int F   = 10;
    localparam int ON  = 3;
    localparam int BH  = 125;
    localparam int WIN = 4000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic [W-1:0] avail = '0;
    logic [W-1:0] learned = '0;
    logic [1:0]   disp_mode = 2'b10;
    logic         charging = 1'b0;
    logic         early_empty = 1'b0;
    logic         final_empty = 1'b0;
    logic [4:0]   seg_out;
    logic         com_out;

    int    checks = 0;
    int    fails = 0;
    bit    tick_rand = 1'b0;
    string cur_req = "R10";

    ledbar_drv #(.W(W), .NSEG(5), .FRAME_TICKS(F), .ON_TICKS(ON),
                 .BLINK_HALF_TICKS(BH), .WINDOW_TICKS(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .avail(avail), .learned(learned),
        .disp_mode(disp_mode), .charging(charging), .early_empty(early_empty),
        .final_empty(final_empty), .seg_out(seg_out), .com_out(com_out)
    );

    always #2 clk = ~clk;

    always @(negedge clk) tick = tick_rand ? 1'($urandom_range(0, 1)) : 1'b1;

    // behavioural reference model
    int         m_ph, m_bc, m_tmr, m_st;
    bit         m_vis, m_prevlow;
    logic [4:0] exp_seg = '0;
    logic       exp_com = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        bit         en, ba, bb, press, showc;
        logic [4:0] s;
        longint     a5;
        if (!rst_n) begin
            m_ph = 0; m_bc = 0; m_tmr = 0; m_st = 0; m_vis = 1; m_prevlow = 0;
            exp_seg = '0; exp_com = 1'b0;
        end else begin
            en = (m_st != 0);
            ba = (m_ph < ON);
            bb = (m_ph >= F / 2) && (m_ph < F / 2 + ON);
            a5 = longint'(avail) * 5;
            for (int k = 0; k < 5; k++)
                s[k] = en && !final_empty && (a5 > longint'(learned) * k)
                       && ((k % 2 == 0) ? ba : bb) && (k != 0 || !early_empty || m_vis);
            exp_seg = s;
            exp_com = en && (ba || bb);
            if (tick) begin
                m_ph = (m_ph + 1) % F;
                if (m_bc == BH - 1) begin m_bc = 0; m_vis = !m_vis; end
                else m_bc++;
            end
            press = (disp_mode == 2'b00) && !m_prevlow;
            m_prevlow = (disp_mode == 2'b00);
            showc = (disp_mode == 2'b01) && charging;
            if (disp_mode[1]) begin m_st = 0; m_tmr = 0; end
            else if (press) begin m_st = 1; m_tmr = 0; end
            else if (m_st == 0) begin if (showc) m_st = 2; end
            else if (m_st == 1) begin
                if (tick) begin
                    if (m_tmr == WIN - 1) begin m_tmr = 0; m_st = showc ? 2 : 0; end
                    else m_tmr++;
                end
            end else if (!showc) m_st = 0;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) chk(cur_req, "cycle compare {com,seg}",
                       int'({com_out, seg_out}), int'({exp_com, exp_seg}));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_com(int n, output int cnt);
        cnt = 0;
        repeat (n) begin @(negedge clk); if (com_out) cnt++; end
    endtask

    task automatic seg_union(int n, output logic [4:0] u);
        u = '0;
        repeat (n) begin @(negedge clk); u |= seg_out; end
    endtask

    task automatic press_low();
        disp_mode = 2'b00; cyc(3); disp_mode = 2'b01;
    endtask

    task automatic level(int a, logic [4:0] exp);
        logic [4:0] u;
        avail = W'(a); cyc(2);
        seg_union(F, u);
        chk("R1", $sformatf("segment set for avail=%0d", a), int'(u), int'(exp));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        int         cnt, cnt2;
        logic [4:0] u;
        cyc(3);
        chk("R10", "seg after reset", int'(seg_out), 0);
        chk("R10", "com after reset", int'(com_out), 0);
        rst_n = 1'b1;
        cyc(2);

        // R1/R4: floating and charging, level sweep
        cur_req = "R1";
        learned = 16'd1000; disp_mode = 2'b01; charging = 1'b1; cyc(3);
        count_com(50, cnt);
        chk("R4", "com cycles while charging", cnt, 30);
        level(0, 5'b00000);
        level(1, 5'b00001);
        level(200, 5'b00001);
        level(201, 5'b00011);
        level(400, 5'b00011);
        level(401, 5'b00111);
        level(601, 5'b01111);
        level(800, 5'b01111);
        level(801, 5'b11111);
        level(1500, 5'b11111);
        avail = 16'd1000;

        // R4: floating without charge
        cur_req = "R4";
        charging = 1'b0; cyc(3);
        count_com(50, cnt);
        chk("R4", "com cycles floating idle", cnt, 0);

        // R3: forced off with both high codes
        cur_req = "R3";
        charging = 1'b1; disp_mode = 2'b10; cyc(3);
        count_com(50, cnt);
        chk("R3", "com cycles mode 10", cnt, 0);
        disp_mode = 2'b11; cyc(3);
        seg_union(50, u);
        chk("R3", "segments mode 11", int'(u), 0);
        chk("R9", "com while off", int'(com_out), 0);

        // R5: timed window, then held low
        cur_req = "R5";
        charging = 1'b0; disp_mode = 2'b01; cyc(2);
        disp_mode = 2'b00; cyc(3);
        count_com(50, cnt);
        chk("R5", "com cycles inside window", cnt, 30);
        cyc(WIN + 20);
        count_com(50, cnt);
        chk("R5", "com cycles after window held low", cnt, 0);

        // R6: restart by a second press
        cur_req = "R6";
        disp_mode = 2'b01; cyc(2);
        press_low();
        cyc(2000);
        press_low();
        cyc(3000);
        count_com(50, cnt);
        chk("R6", "com cycles past first expiry", cnt, 30);
        cyc(1100);
        count_com(50, cnt);
        chk("R6", "com cycles after restarted expiry", cnt, 0);

        // R7: blink on segment 1 only
        cur_req = "R7";
        charging = 1'b1; early_empty = 1'b1; cyc(3);
        cnt = 0; cnt2 = 0;
        repeat (2 * BH) begin
            @(negedge clk);
            if (seg_out[0]) cnt++;
            if (seg_out[2]) cnt2++;
        end
        chk("R7", "segment 3 cycles over blink period", cnt2, 2 * BH * ON / F);
        chk("R7", "segment 1 blinked below segment 3", int'(cnt > 0 && cnt < cnt2), 1);
        early_empty = 1'b0;

        // R8: final empty blanks segments, keeps common
        cur_req = "R8";
        final_empty = 1'b1; cyc(2);
        seg_union(50, u);
        chk("R8", "segments under final empty", int'(u), 0);
        count_com(50, cnt);
        chk("R8", "com cycles under final empty", cnt, 30);
        final_empty = 1'b0;

        // R2: irregular ticks with changing levels
        cur_req = "R2";
        tick_rand = 1'b1;
        for (int i = 0; i < 40; i++) begin
            avail = W'($urandom_range(0, 1200));
            cyc(15);
        end
        tick_rand = 1'b0;
        cyc(5);
        finish_run();
    end

endmodule